// File: doc/BRIEF.md
# Hierarchical 32-Way Rotating Bus Arbiter

This block grants a shared bus to one of 32 requesters per clock cycle. Requests arrive already synchronized. Each cycle the block picks at most one winner and registers its acknowledge, so the grant used in cycle n is decided during cycle n-1. Arbitration can then overlap with the data transfer of the previous winner.

The choice is made by a three-level tree of small rotating-priority cells:

- **Level 1.** Eight four-input cells each pick a winner inside a group of four devices. Each group also produces a group-request signal, the OR of its four requests.
- **Level 2.** Two four-input cells pick a winning group inside each half. Groups 0 to 3 form half 0 and groups 4 to 7 form half 1.
- **Level 3.** A two-input cell picks the winning half.

A device is acknowledged only when it wins at all three levels. All priority states come from a single free-running 5-bit counter, so no grant history is stored and no illegal state can arise. A parameter selects how the counter bits are assigned to the levels. The default lets the level-3 bit change fastest, which gives requesters a less regular priority pattern.

Top module: `arb_tree32`

## Requirements
- R1: While reset is active and on its release, every acknowledge is low and the priority counter holds zero, so the first arbitration after reset uses counter value 0.
- R2: Acknowledges are registered. Requests present at a rising edge produce their acknowledge after that edge, and a device is never acknowledged unless its request was high at that edge.
- R3: At most one acknowledge is high in any cycle, and exactly one is high whenever at least one request was high at the preceding edge.
- R4: Device d belongs to group d/4 at position d%4. Inside a group with level-1 state k (0..3), the priority order from highest to lowest is position k, k-1, k-2, k-3 (modulo 4).
- R5: Group g belongs to half g/4 at slot g%4. A group requests whenever any of its four devices requests. Inside a half with level-2 state k, slots are ranked k, k-1, k-2, k-3 (modulo 4).
- R6: At level 3, state 0 gives half 0 priority over half 1, and state 1 gives half 1 priority over half 0.
- R7: The 5-bit counter increments by one on every clock cycle out of reset and wraps from 31 to 0.
- R8: With the default ordering (ORDER_442 = 0), the level-3 state is counter bit 0, the level-2 state is counter bits [2:1], and the level-1 state is counter bits [4:3]. All level-1 cells share one state, and both level-2 cells share one state.
- R9: With ORDER_442 = 1, the level-1 state is counter bits [1:0], the level-2 state is counter bits [3:2], and the level-3 state is counter bit 4.
- R10: With all 32 requests held high, each device is acknowledged exactly once in every 32 consecutive cycles.
- R11: A device's acknowledge is the AND of its wins at the three levels: it wins in its group, its group wins in its half, and its half wins at the top.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Synchronized bus requests, one per device |
| ack_o | output | 32 | Registered acknowledges, at most one high |

## Verification
Every acknowledge is due exactly one rising edge after the requests it answers. The counter state that ranks those requests is the value held just before that same edge. The bench therefore changes requests only on falling edges. At each rising edge it advances its own counter model, computes the expected grant from the requests and the modelled counter, and compares the outputs at the next falling edge. Because the counter model starts from zero at reset release and steps once per edge, any slip in latency or counter order shows up as a mismatch in the very next comparison.

// File: rtl/arb_tree_pkg.sv
package arb_tree_pkg;
    localparam int GRP_SIZE = 4;
    localparam int N_GRP    = 8;
    localparam int N_HALF   = 2;
    localparam int GRP_PER_HALF = N_GRP / N_HALF;
    localparam int N_DEV    = GRP_SIZE * N_GRP;
    localparam int SEL4_W   = $clog2(GRP_SIZE);
    localparam int CTR_W    = 2 * SEL4_W + $clog2(N_HALF);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             seen;
    } ctr_state_t;

    typedef struct packed {
        logic [N_DEV-1:0] ack;
    } ack_state_t;
endpackage

// File: rtl/arb_state_ctr.sv
module arb_state_ctr
    import arb_tree_pkg::*;
#(
    parameter bit ORDER_442 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SEL4_W-1:0] sel_l1_o,
    output logic [SEL4_W-1:0] sel_l2_o,
    output logic              sel_l3_o
);
    ctr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (ORDER_442) begin : g_ord442
            assign sel_l1_o = st_q.cnt[SEL4_W-1:0];
            assign sel_l2_o = st_q.cnt[2*SEL4_W-1:SEL4_W];
            assign sel_l3_o = st_q.cnt[CTR_W-1];
        end else begin : g_ord244
            assign sel_l3_o = st_q.cnt[0];
            assign sel_l2_o = st_q.cnt[SEL4_W:1];
            assign sel_l1_o = st_q.cnt[CTR_W-1:SEL4_W+1];
        end
    endgenerate

    // R7: counter steps by one per cycle, wrapping naturally
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen |-> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R1: counter is zero while reset holds
    a_r1_ctr_reset: assert property (@(posedge clk)
        !rst_n |-> (st_q.cnt == '0));
endmodule

// File: rtl/arb_rot4.sv
module arb_rot4
    import arb_tree_pkg::*;
(
    input  logic [GRP_SIZE-1:0] req_i,
    input  logic [SEL4_W-1:0]   sel_i,
    output logic [GRP_SIZE-1:0] gnt_o,
    output logic                any_o
);
    always_comb begin
        logic             found;
        logic [SEL4_W-1:0] idx;
        gnt_o = '0;
        found = 1'b0;
        for (int rk = 0; rk < GRP_SIZE; rk++) begin
            idx = sel_i - SEL4_W'(rk);
            if (!found && req_i[idx]) begin
                gnt_o[idx] = 1'b1;
                found      = 1'b1;
            end
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/arb_rot2.sv
module arb_rot2 (
    input  logic [1:0] req_i,
    input  logic       sel_i,
    output logic [1:0] gnt_o
);
    always_comb begin
        gnt_o = 2'b00;
        if (req_i[sel_i])       gnt_o[sel_i]  = 1'b1;
        else if (req_i[!sel_i]) gnt_o[!sel_i] = 1'b1;
    end
endmodule

// File: rtl/arb_tree32.sv
module arb_tree32
    import arb_tree_pkg::*;
#(
    parameter bit ORDER_442 = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] req_i,
    output logic [N_DEV-1:0] ack_o
);
    logic [SEL4_W-1:0]   sel_l1, sel_l2;
    logic                sel_l3;
    logic [GRP_SIZE-1:0] l1_gnt [N_GRP];
    logic [N_GRP-1:0]    grp_any;
    logic [GRP_SIZE-1:0] l2_gnt [N_HALF];
    logic [N_HALF-1:0]   half_any;
    logic [1:0]          l3_gnt;

    arb_state_ctr #(.ORDER_442(ORDER_442)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_l1_o (sel_l1),
        .sel_l2_o (sel_l2),
        .sel_l3_o (sel_l3)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_l1
        arb_rot4 u_cell (
            .req_i (req_i[g*GRP_SIZE +: GRP_SIZE]),
            .sel_i (sel_l1),
            .gnt_o (l1_gnt[g]),
            .any_o (grp_any[g])
        );
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_l2
        arb_rot4 u_cell (
            .req_i (grp_any[h*GRP_PER_HALF +: GRP_PER_HALF]),
            .sel_i (sel_l2),
            .gnt_o (l2_gnt[h]),
            .any_o (half_any[h])
        );
    end

    arb_rot2 u_top (
        .req_i (half_any),
        .sel_i (sel_l3),
        .gnt_o (l3_gnt)
    );

    ack_state_t ack_d, ack_q;

    always_comb begin
        ack_d = '0;
        for (int d = 0; d < N_DEV; d++) begin
            ack_d.ack[d] = l1_gnt[d / GRP_SIZE][d % GRP_SIZE]
                         & l2_gnt[d / (GRP_SIZE*GRP_PER_HALF)][(d / GRP_SIZE) % GRP_PER_HALF]
                         & l3_gnt[d / (GRP_SIZE*GRP_PER_HALF)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign ack_o = ack_q.ack;

    // R1: no acknowledge during reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (ack_o == '0));

    // R3: never more than one acknowledge
    a_r3_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    // R3: some request implies a grant on the next cycle
    a_r3_no_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> (|ack_o));

    // R2: only a device that requested can be acknowledged
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o & ~$past(req_i)) == '0);
endmodule

// File: tb/test_arb_tree32.sv
module test_arb_tree32;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic [31:0] ack_a, ack_b;
    logic [4:0]  mcnt = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    arb_tree32 #(.ORDER_442(1'b0)) i_arb_tree32 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack_a));
    arb_tree32 #(.ORDER_442(1'b1)) i_arb_tree32_alt (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack_b));

    function automatic logic [3:0] pick4(input logic [3:0] r, input logic [1:0] s);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] p;
            p = s - 2'(k);
            if (r[p]) return 4'b1 << p;
        end
        return 4'b0;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] r, input logic [4:0] c, input bit alt);
        logic [1:0]  s1, s2;
        logic        s3;
        logic [7:0]  gany;
        logic [3:0]  gw [8];
        logic [3:0]  hw [2];
        logic [1:0]  hany;
        int          half;
        logic [31:0] res;
        if (alt) begin s1 = c[1:0]; s2 = c[3:2]; s3 = c[4]; end
        else     begin s3 = c[0];   s2 = c[2:1]; s1 = c[4:3]; end
        for (int g = 0; g < 8; g++) begin
            gw[g]   = pick4(r[g*4 +: 4], s1);
            gany[g] = |r[g*4 +: 4];
        end
        for (int h = 0; h < 2; h++) begin
            hw[h]   = pick4(gany[h*4 +: 4], s2);
            hany[h] = |gany[h*4 +: 4];
        end
        half = -1;
        if (hany[s3]) half = int'(s3);
        else if (hany[!s3]) half = int'(!s3);
        res = '0;
        if (half >= 0) begin
            for (int j = 0; j < 4; j++)
                if (hw[half][j]) begin
                    for (int p = 0; p < 4; p++)
                        if (gw[half*4 + j][p]) res[half*16 + j*4 + p] = 1'b1;
                end
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input string tag, input logic [31:0] r);
        logic [31:0] ea, eb;
        req = r;
        @(posedge clk);
        ea = model(r, mcnt, 1'b0);
        eb = model(r, mcnt, 1'b1);
        mcnt = mcnt + 1'b1;
        @(negedge clk);
        check({tag, " default order"}, ack_a, ea);
        check({tag, " alt order"}, ack_b, eb);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 in reset", ack_a, '0);
        check("R1 in reset alt", ack_b, '0);
        rst_n = 1'b1;
        mcnt  = '0;
        // R1: first arbitration uses counter 0 -> with all requests device 0 wins (default)
        req = '1;
        @(posedge clk);
        mcnt = 5'd1;
        @(negedge clk);
        check("R1 first grant state 0", ack_a, 32'h1);
        check("R1 first grant state 0 alt", ack_b, 32'h1);
    endtask

    task automatic t_idle;
        for (int i = 0; i < 4; i++) step("R3 idle", '0);
    endtask

    task automatic t_single;
        for (int d = 0; d < 32; d++) begin
            step("R2 single", 32'h1 << d);
            check("R2 single device only", ack_a, 32'h1 << d);
        end
    endtask

    task automatic t_in_group;
        for (int i = 0; i < 40; i++) step("R4 group rotation", 32'h0000_000B);
        for (int i = 0; i < 32; i++) step("R4 R8 full group", 32'h0000_00F0);
    endtask

    task automatic t_across;
        for (int i = 0; i < 32; i++) step("R5 groups in half", 32'h0000_1221);
        for (int i = 0; i < 32; i++) step("R6 halves", 32'h0010_0008);
        for (int i = 0; i < 32; i++) step("R11 path and", 32'h8421_8421);
    endtask

    task automatic t_all;
        int hits_a [32];
        int hits_b [32];
        for (int d = 0; d < 32; d++) begin hits_a[d] = 0; hits_b[d] = 0; end
        for (int i = 0; i < 32; i++) begin
            step("R7 R10 all requests", '1);
            for (int d = 0; d < 32; d++) begin
                if (ack_a[d]) hits_a[d]++;
                if (ack_b[d]) hits_b[d]++;
            end
        end
        for (int d = 0; d < 32; d++) begin
            check("R10 once per 32 default", 32'(hits_a[d]), 32'd1);
            check("R10 once per 32 alt", 32'(hits_b[d]), 32'd1);
        end
    endtask

    task automatic t_mixed;
        logic [31:0] x = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            step("R8 R9 mixed", (i % 3 == 0) ? (x & (x >> 7)) : x);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_single();
        t_in_group();
        t_across();
        t_all();
        t_mixed();
        t_all();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule